// File: doc/BRIEF.md
# Exact Posit Dot-Product Accumulator

This block sums products of 8-bit posit operands (2-bit exponent field) without any rounding. Each accepted operand pair is decoded. The two significands are multiplied exactly, and the product is shifted to a fixed binary point inside a wide two's-complement register, the quire. The product is then added to the quire or subtracted from it. Because the quire has a fixed-point layout wide enough for every product plus many carry bits, a dot product of billions of terms stays exact.

Operand pairs arrive on a valid/ready stream. A pair transfers on a rising edge where `in_valid` and `in_ready` are both high. The source must hold `op_a`, `op_b` and `sub` stable while `in_valid` is high and `in_ready` is low. The block drops `in_ready` only while `clear` is high. In every other cycle it takes one pair, with no stall. `clear` is a plain control that starts a new dot product. The raw quire and a not-a-real flag are visible at all times. Turning the quire back into a posit is left to a later stage.

Top module: `pqd_dot_accum`

## Requirements
- R1: An operand is decoded as follows. Bit 7 is the sign, and a negative posit is the two's complement of its magnitude. A run of identical bits after the sign, ended by the opposite bit or by the end of the word, gives the regime k: a run of m ones gives k = m-1, and a run of m zeros gives k = -m. The next 2 bits are the exponent e, and the up to 3 bits after that are the fraction f. Missing bits read as 0. The magnitude is 2^(4k+e)·(1+f). Examples: 0x40 = 1.0, 0x48 = 2.0, 0x44 = 1.5, 0xC0 = -1.0, 0x01 = 2^-24, 0x7F = 2^24.
- R2: The quire is a 128-bit two's-complement integer whose bit 0 weighs 2^-48. This is the square of the smallest positive posit. So 1.0·1.0 reads 2^48, 0x01·0x01 reads 1, and 0x7F·0x7F reads 2^96.
- R3: Each accepted pair whose operands are neither zero nor NaR adds the exact product a·b to the quire, with no rounding.
- R4: When `sub` is high with an accepted pair, the exact product is subtracted from the quire instead of added.
- R5: If either operand of an accepted pair is NaR (0x80), the quire becomes the NaR pattern: bit 127 set and all other bits clear. `quire_nar` goes high. The quire keeps that pattern, whatever pairs follow, until it is cleared.
- R6: An accepted pair with a zero operand (0x00) leaves the quire unchanged.
- R7: A rising edge with `clear` high sets the quire to zero and drops a pair still in flight. `in_ready` is low while `clear` is high, so no pair is taken in that cycle.
- R8: A pair is accepted on an edge with `in_valid` and `in_ready` both high. Its effect on the quire is visible after the next rising edge. One pair is taken every cycle. Edges without acceptance add nothing.
- R9: After reset, the quire reads zero and `quire_nar` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Zero the quire and flush the pipeline |
| sub | input | 1 | Subtract this pair's product instead of adding it |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take a pair this cycle |
| op_a | input | 8 | First posit operand |
| op_b | input | 8 | Second posit operand |
| quire_out | output | 128 | Raw quire contents |
| quire_nar | output | 1 | Quire holds the NaR pattern |

## Verification
The bench builds the block with its default parameters: an 8-bit posit, a 2-bit exponent field and a 128-bit quire. With an 8-bit word, a few thousand random pairs cover every operand code, including zero, NaR, the smallest and largest posits, and both signs. The same setting puts the extreme products directly at quire bit 0 and bit 96. A reference model in the bench decodes each posit by walking its bits and computes the sum with 128-bit integers, so carries, subtraction and long accumulations are checked exactly.

// File: rtl/pqd_pkg.sv
package pqd_pkg;
  // Widths generous enough for any posit word up to 16 bits.
  localparam int SCALE_W = 10;
  localparam int MANT_W  = 16;

  typedef struct packed {
    logic                      sign;
    logic                      zero;
    logic                      nar;
    logic signed [SCALE_W-1:0] scale;
    logic [MANT_W-1:0]         mant;   // hidden one plus fraction, fraction left aligned
  } dec_t;
endpackage

// File: rtl/pqd_posit_decode.sv
module pqd_posit_decode
  import pqd_pkg::*;
#(
  parameter int N  = 8,
  parameter int ES = 2
) (
  input  logic [N-1:0] word,
  output dec_t         dec
);
  localparam int BW  = N - 1;
  localparam int FW  = N - 3 - ES;
  localparam int RLW = $clog2(N) + 1;

  logic [N-1:0]  mag;
  logic [BW-1:0] body;
  logic [BW-1:0] shifted;
  logic          run_bit;
  logic          found;
  logic [RLW-1:0] run_len;
  logic [ES-1:0] expo;
  logic [FW-1:0] frac;
  logic signed [SCALE_W-1:0] regime;

  always_comb begin
    mag     = word[N-1] ? (~word + 1'b1) : word;
    body    = mag[BW-1:0];
    run_bit = body[BW-1];
    run_len = RLW'(BW);
    found   = 1'b0;
    for (int i = BW - 1; i >= 0; i--) begin
      if (!found && body[i] != run_bit) begin
        run_len = RLW'(BW - 1 - i);
        found   = 1'b1;
      end
    end
    shifted = body << (run_len + 1'b1);
    expo    = shifted[BW-1 -: ES];
    frac    = shifted[BW-1-ES -: FW];
    regime  = run_bit ? (SCALE_W'(run_len) - 1'b1) : (-SCALE_W'(run_len));
    dec.sign  = word[N-1];
    dec.zero  = (word == '0);
    dec.nar   = (word == {1'b1, {(N-1){1'b0}}});
    dec.scale = (regime <<< ES) + SCALE_W'(expo);
    dec.mant  = MANT_W'({1'b1, frac});
  end
endmodule

// File: rtl/pqd_align.sv
module pqd_align
  import pqd_pkg::*;
#(
  parameter int N  = 8,
  parameter int ES = 2,
  parameter int QW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          sub,
  input  dec_t          dec_a,
  input  dec_t          dec_b,
  output logic          stg_vld,
  output logic          stg_nar,
  output logic [QW-1:0] stg_term
);
  localparam int FW    = N - 3 - ES;
  localparam int MW    = FW + 1;
  localparam int PW    = 2 * MW;
  localparam int MAXSC = (N - 2) * (1 << ES);
  localparam int OFF   = 2 * MAXSC;
  localparam int SW    = QW + 2 * FW;

  logic [PW-1:0]      prod;
  logic [SCALE_W:0]   pos;
  logic [SW-1:0]      wide;
  logic [QW-1:0]      mag;
  logic [QW-1:0]      term;
  logic               neg;

  always_comb begin
    prod = dec_a.mant[MW-1:0] * dec_b.mant[MW-1:0];
    pos  = {dec_a.scale[SCALE_W-1], dec_a.scale} + {dec_b.scale[SCALE_W-1], dec_b.scale}
           + (SCALE_W+1)'(OFF);
    wide = SW'(prod) << pos;
    mag  = wide[SW-1:2*FW];
    neg  = dec_a.sign ^ dec_b.sign ^ sub;
    if (dec_a.zero || dec_b.zero) term = '0;
    else if (neg)                 term = ~mag + 1'b1;
    else                          term = mag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_vld  <= 1'b0;
      stg_nar  <= 1'b0;
      stg_term <= '0;
    end else begin
      stg_vld <= take;
      if (take) begin
        stg_nar  <= dec_a.nar | dec_b.nar;
        stg_term <= term;
      end
    end
  end
endmodule

// File: rtl/pqd_accum.sv
module pqd_accum #(
  parameter int QW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          stg_vld,
  input  logic          stg_nar,
  input  logic [QW-1:0] stg_term,
  output logic [QW-1:0] quire
);
  localparam logic [QW-1:0] NAR_Q = {1'b1, {(QW-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quire <= '0;
    end else if (clear) begin
      quire <= '0;
    end else if (stg_vld && quire != NAR_Q) begin
      quire <= stg_nar ? NAR_Q : (quire + stg_term);
    end
  end
endmodule

// File: rtl/pqd_dot_accum.sv
module pqd_dot_accum
  import pqd_pkg::*;
#(
  parameter int N  = 8,
  parameter int ES = 2,
  parameter int QW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sub,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N-1:0]  op_a,
  input  logic [N-1:0]  op_b,
  output logic [QW-1:0] quire_out,
  output logic          quire_nar
);
  logic [N-1:0]  ops [2];
  dec_t          decs [2];
  logic          take;
  logic          stg_vld;
  logic          stg_nar;
  logic [QW-1:0] stg_term;

  assign ops[0]   = op_a;
  assign ops[1]   = op_b;
  assign in_ready = !clear;
  assign take     = in_valid && in_ready;

  for (genvar g = 0; g < 2; g++) begin : g_dec
    pqd_posit_decode #(.N(N), .ES(ES)) u_dec (
      .word (ops[g]),
      .dec  (decs[g])
    );
  end

  pqd_align #(.N(N), .ES(ES), .QW(QW)) u_align (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .sub      (sub),
    .dec_a    (decs[0]),
    .dec_b    (decs[1]),
    .stg_vld  (stg_vld),
    .stg_nar  (stg_nar),
    .stg_term (stg_term)
  );

  pqd_accum #(.QW(QW)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .stg_vld  (stg_vld),
    .stg_nar  (stg_nar),
    .stg_term (stg_term),
    .quire    (quire_out)
  );

  assign quire_nar = (quire_out == {1'b1, {(QW-1){1'b0}}});
endmodule

// File: rtl/pqd_checker.sv
module pqd_checker #(
  parameter int N  = 8,
  parameter int QW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear,
  input logic          in_valid,
  input logic          in_ready,
  input logic [N-1:0]  op_a,
  input logic [N-1:0]  op_b,
  input logic [QW-1:0] quire_out,
  input logic          quire_nar
);
  localparam logic [N-1:0] NAR_W = {1'b1, {(N-1){1'b0}}};
  logic acc;
  assign acc = in_valid && in_ready;

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (quire_out == '0 && !quire_nar));

  assert_clear_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !in_ready);

  assert_nar_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (quire_nar && !clear) |=> quire_nar);

  assert_nar_operand_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op_a == NAR_W || op_b == NAR_W)) ##1 !clear |=> quire_nar);

  assert_zero_operand_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op_a == '0 || op_b == '0)) ##1 !clear |=> $stable(quire_out));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc) ##1 !clear |=> $stable(quire_out));
endmodule

bind pqd_dot_accum pqd_checker #(.N(N), .QW(QW)) chk_i (.*);

// File: tb/pqd_dot_accum_tb.sv
module pqd_dot_accum_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [127:0] NARQ = {1'b1, 127'b0};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clear = 1'b0;
  logic         sub = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [7:0]   op_a = '0;
  logic [7:0]   op_b = '0;
  logic [127:0] quire_out;
  logic         quire_nar;

  int vectors = 0;
  int fails = 0;

  // reference state
  logic signed [127:0] mq = '0;
  logic                mnar = 1'b0;
  logic                pend_v = 1'b0;
  logic                pend_nar = 1'b0;
  logic signed [127:0] pend_term = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pqd_dot_accum dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .sub(sub),
    .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b),
    .quire_out(quire_out), .quire_nar(quire_nar)
  );

  task automatic check(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // posit value times 2^27, found by walking the bits (R1)
  function automatic logic signed [127:0] pval(input logic [7:0] p);
    logic [7:0] x;
    logic r;
    int i, m, e, f, k, sc;
    logic signed [127:0] v;
    if (p == 8'h00 || p == 8'h80) return '0;
    x = p[7] ? (8'h00 - p) : p;
    r = x[6]; i = 6; m = 0;
    while (i >= 0 && x[i] == r) begin m++; i--; end
    i--;
    e = 0;
    for (int j = 0; j < 2; j++) begin e = e * 2 + ((i >= 0) ? int'(x[i]) : 0); i--; end
    f = 0;
    for (int j = 0; j < 3; j++) begin f = f * 2 + ((i >= 0) ? int'(x[i]) : 0); i--; end
    k = r ? m - 1 : -m;
    sc = 4 * k + e;
    v = 128'(8 + f) <<< (sc + 24);
    return p[7] ? -v : v;
  endfunction

  function automatic logic [127:0] expected_q();
    return mnar ? NARQ : mq;
  endfunction

  // one clock: drive, check ready, step the model, compare outputs
  task automatic cycle(input logic v, input logic [7:0] a, input logic [7:0] b,
                       input logic s, input logic c);
    in_valid = v; op_a = a; op_b = b; sub = s; clear = c;
    #1;
    check(in_ready == !c, "R7 ready", 128'(in_ready), 128'(!c));
    @(posedge clk);
    if (c) begin
      mq = '0; mnar = 1'b0; pend_v = 1'b0;
    end else begin
      if (pend_v && !mnar) begin
        if (pend_nar) mnar = 1'b1;
        else mq = mq + pend_term;
      end
      pend_v = v;
      if (v) begin
        pend_nar  = (a == 8'h80) || (b == 8'h80);
        pend_term = (pval(a) * pval(b)) / 64;
        if (s) pend_term = -pend_term;
      end
    end
    @(negedge clk);
    check(quire_out == expected_q(), "R3 R4 R8 model", quire_out, expected_q());
    check(quire_nar == mnar, "R5 flag", 128'(quire_nar), 128'(mnar));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic expect_q(input logic [127:0] exp, input string req);
    check(quire_out == exp, req, quire_out, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(quire_out == '0 && !quire_nar, "R9 reset", quire_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(quire_out == '0, "R9 after release", quire_out, '0);

    // R1 R2: 1.0*1.0
    cycle(1, 8'h40, 8'h40, 0, 0); idle(1);
    expect_q(128'd1 << 48, "R2 one squared");
    cycle(0, 0, 0, 0, 1);
    // R2: minpos squared lands on bit 0
    cycle(1, 8'h01, 8'h01, 0, 0); idle(1);
    expect_q(128'd1, "R2 minpos squared");
    cycle(0, 0, 0, 0, 1);
    // R2: maxpos squared
    cycle(1, 8'h7F, 8'h7F, 0, 0); idle(1);
    expect_q(128'd1 << 96, "R2 maxpos squared");
    cycle(0, 0, 0, 0, 1);
    // R1 R3: 2.0*1.5 = 3
    cycle(1, 8'h48, 8'h44, 0, 0); idle(1);
    expect_q(128'd3 << 48, "R1 R3 two times one-and-half");
    cycle(0, 0, 0, 0, 1);
    // R1: negative operand
    cycle(1, 8'hC0, 8'h40, 0, 0); idle(1);
    expect_q(-(128'd1 << 48), "R1 negative one");
    cycle(0, 0, 0, 0, 1);
    // R4: subtract
    cycle(1, 8'h40, 8'h40, 1, 0); idle(1);
    expect_q(-(128'd1 << 48), "R4 subtract");
    cycle(0, 0, 0, 0, 1);
    // R8: back-to-back pairs, latency
    cycle(1, 8'h40, 8'h40, 0, 0);
    expect_q('0, "R8 not yet visible");
    cycle(1, 8'h40, 8'h40, 0, 0);
    expect_q(128'd1 << 48, "R8 first visible");
    cycle(1, 8'h40, 8'h40, 0, 0); idle(1);
    expect_q(128'd3 << 48, "R8 three pairs");
    // R6: zero operand leaves quire alone
    cycle(1, 8'h00, 8'h7F, 0, 0); idle(1);
    expect_q(128'd3 << 48, "R6 zero operand");
    // R7: clear drops in-flight pair
    cycle(1, 8'h40, 8'h40, 0, 0);
    cycle(1, 8'h7F, 8'h7F, 0, 1); idle(2);
    expect_q('0, "R7 clear flushes");
    // R5: NaR sticky
    cycle(1, 8'h80, 8'h40, 0, 0); idle(1);
    expect_q(NARQ, "R5 NaR operand");
    cycle(1, 8'h40, 8'h40, 0, 0);
    cycle(1, 8'h01, 8'hFF, 1, 0); idle(1);
    expect_q(NARQ, "R5 NaR sticky");
    cycle(0, 0, 0, 0, 1);
    expect_q('0, "R5 R7 NaR cleared");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic v, s, c;
      v = ($urandom_range(0, 9) < 7);
      s = $urandom_range(0, 1);
      c = ($urandom_range(0, 49) == 0);
      cycle(v, 8'($urandom), 8'($urandom), s, c);
    end
    // long exact accumulation of large products
    cycle(0, 0, 0, 0, 1);
    for (int n = 0; n < 300; n++) cycle(1, 8'h7F, 8'h7E, n[0], 0);
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule